// File: doc/BRIEF.md
# Addressed Serial Configuration Register Port

This block is a write-only configuration port driven over three wires: a serial clock, a serial data line and a commit strobe. Each write is a 16-bit word sent most significant bit first. A rising edge on the serial clock shifts one bit into the word. A rising edge on the strobe commits the word. The two lowest bits of the word pick the destination register, and the upper fourteen bits are the payload. The block holds two channel-volume registers and one control register.

The three serial wires are asynchronous to the system clock. Each passes through a synchronizer, and its edges are found in the system clock domain. The control register is decoded into separate configuration fields. Several of those fields are combined with external strap pins, so a board without a serial host can still set the mode, the interpolation ratio and mute. Downstream blocks get a one-cycle pulse for each register written, along with the current volume words.

Top module: `serctl_regs`

## Requirements
- R1: After reset, with all strap pins low: both volume outputs are 14'h3FFF; intpX2, intpX4, softReset, muteEff and the modeEff, wordLen and deemphSel fields are all zero (8x interpolation, 24-bit right-justified, unmuted, no de-emphasis).
- R2: Bits are sampled on rising edges of sclkIn, most significant bit first. A rising edge of latchIn commits the most recent 16 bits. Any earlier bits sent before those 16 have no effect.
- R3: The low two bits of the committed word select the target: 00 selects left volume, 10 selects right volume, 01 selects control. Code 11 changes no register and raises no write pulse.
- R4: Each commit raises exactly one write pulse (wrLeft, wrRight or wrCtrl), for one cycle, in the same cycle that the new register value appears.
- R5: A volume commit loads word bits 15:2 into that channel's volume and leaves the other registers unchanged.
- R6: Control field positions in the word: bit 11 selects 2x interpolation, bit 10 selects 4x, bits 9:8 give the right-justified word length (00=24, 01=20, 10=16), bit 7 is soft reset, bit 6 is mute, bits 5:4 give the serial mode, and bits 3:2 give the de-emphasis curve (00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz).
- R7: Control word bits 15:12 have no effect on any output.
- R8: intpX2, intpX4, muteEff and each bit of modeEff are the OR of the register bit and the matching strap pin. When the de-emphasis pin is high, deemphSel reads 01 whatever the register holds.
- R9: If a serial clock rise and a strobe rise are detected in the same cycle, the commit uses the word as it was before that clock's bit. The bit is still shifted in afterwards.
- R10: Driving rstN low returns all registers to their R1 defaults, even after writes.
- R11: Setting the soft-reset bit does not clear the control register. softReset and the other control fields keep their values until the next control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclkIn | input | 1 | Serial bit clock, asynchronous |
| sdataIn | input | 1 | Serial data, MSB first |
| latchIn | input | 1 | Commit strobe, rising edge active |
| pinX2 | input | 1 | Strap: 2x interpolation |
| pinX4 | input | 1 | Strap: 4x interpolation |
| pinMode | input | 2 | Strap: serial data mode |
| pinMute | input | 1 | Strap: mute |
| pinDeemph | input | 1 | Strap: force 44.1 kHz de-emphasis |
| volLeft | output | 14 | Left volume word |
| volRight | output | 14 | Right volume word |
| wrLeft | output | 1 | One-cycle left volume write pulse |
| wrRight | output | 1 | One-cycle right volume write pulse |
| wrCtrl | output | 1 | One-cycle control write pulse |
| intpX2 | output | 1 | Effective 2x interpolation |
| intpX4 | output | 1 | Effective 4x interpolation |
| wordLen | output | 2 | Right-justified word length code |
| softReset | output | 1 | Soft reset for the downstream datapath |
| muteEff | output | 1 | Effective mute |
| modeEff | output | 2 | Effective serial data mode |
| deemphSel | output | 2 | Effective de-emphasis curve |

## Verification
A serial clock rise and a strobe rise can be detected in the same system cycle, and the two then compete for the shift register. The bench sends a full left-volume word without committing it. It then raises the serial clock, carrying a seventeenth bit, and the strobe on the same clock edge. Both wires pass through synchronizers of equal depth, so the two edges are detected together. The committed left volume must equal the payload of the 16-bit word sent before that bit, which shows the commit used the word from before the shift.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 2;
  localparam int PAY_W  = WORD_W - ADDR_W;
  localparam int CTRL_LO = 2;
  localparam int CTRL_HI = 11;
  localparam int CTRL_W  = CTRL_HI - CTRL_LO + 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LEFT  = 2'b00,
    ADDR_CTRL  = 2'b01,
    ADDR_RIGHT = 2'b10,
    ADDR_NONE  = 2'b11
  } addr_e;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/serctl_front.sv
module serctl_front
  import serctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  input  logic    sdataIn,
  input  logic    latchIn,
  output strobe_t ctl
);
  logic [2:0] syncd;
  logic       sclkPrev;
  logic       latchPrev;

  serctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({latchIn, sdataIn, sclkIn}),
    .syncOut (syncd)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      sclkPrev  <= syncd[0];
      latchPrev <= syncd[2];
    end
  end

  always_comb begin
    ctl.shiftEn  = syncd[0] & ~sclkPrev;
    ctl.shiftBit = syncd[1];
    ctl.commit   = syncd[2] & ~latchPrev;
  end
endmodule

// File: rtl/serctl_regfile.sv
module serctl_regfile
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  output logic [PAY_W-1:0]  volLeft,
  output logic [PAY_W-1:0]  volRight,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              wrLeft,
  output logic              wrRight,
  output logic              wrCtrl
);
  logic [WORD_W-1:0] shiftReg;
  addr_e             target;
  logic [PAY_W-1:0]  payload;

  assign target  = addr_e'(shiftReg[ADDR_W-1:0]);
  assign payload = shiftReg[WORD_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], ctl.shiftBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      volLeft  <= '1;
      volRight <= '1;
      ctrlReg  <= '0;
      wrLeft   <= 1'b0;
      wrRight  <= 1'b0;
      wrCtrl   <= 1'b0;
    end else begin
      wrLeft  <= 1'b0;
      wrRight <= 1'b0;
      wrCtrl  <= 1'b0;
      if (ctl.commit) begin
        unique case (target)
          ADDR_LEFT: begin
            volLeft <= payload;
            wrLeft  <= 1'b1;
          end
          ADDR_RIGHT: begin
            volRight <= payload;
            wrRight  <= 1'b1;
          end
          ADDR_CTRL: begin
            ctrlReg <= shiftReg[CTRL_HI:CTRL_LO];
            wrCtrl  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkIn,
  input  logic             sdataIn,
  input  logic             latchIn,
  input  logic             pinX2,
  input  logic             pinX4,
  input  logic [1:0]       pinMode,
  input  logic             pinMute,
  input  logic             pinDeemph,
  output logic [PAY_W-1:0] volLeft,
  output logic [PAY_W-1:0] volRight,
  output logic             wrLeft,
  output logic             wrRight,
  output logic             wrCtrl,
  output logic             intpX2,
  output logic             intpX4,
  output logic [1:0]       wordLen,
  output logic             softReset,
  output logic             muteEff,
  output logic [1:0]       modeEff,
  output logic [1:0]       deemphSel
);
  strobe_t           ctl;
  logic [CTRL_W-1:0] ctrlReg;

  serctl_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk     (clk),
    .rstN    (rstN),
    .sclkIn  (sclkIn),
    .sdataIn (sdataIn),
    .latchIn (latchIn),
    .ctl     (ctl)
  );

  serctl_regfile i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .volLeft  (volLeft),
    .volRight (volRight),
    .ctrlReg  (ctrlReg),
    .wrLeft   (wrLeft),
    .wrRight  (wrRight),
    .wrCtrl   (wrCtrl)
  );

  // ctrlReg index = word bit - CTRL_LO
  always_comb begin
    intpX2    = ctrlReg[11-CTRL_LO] | pinX2;
    intpX4    = ctrlReg[10-CTRL_LO] | pinX4;
    wordLen   = ctrlReg[9-CTRL_LO:8-CTRL_LO];
    softReset = ctrlReg[7-CTRL_LO];
    muteEff   = ctrlReg[6-CTRL_LO] | pinMute;
    modeEff   = ctrlReg[5-CTRL_LO:4-CTRL_LO] | pinMode;
    deemphSel = pinDeemph ? 2'b01 : ctrlReg[3-CTRL_LO:2-CTRL_LO];
  end
endmodule

// File: rtl/serctl_checker.sv
module serctl_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrLeft,
  input logic        wrRight,
  input logic        wrCtrl,
  input logic [13:0] volLeft,
  input logic [13:0] volRight,
  input logic [1:0]  wordLen,
  input logic        softReset
);
  // R4: at most one target written per commit
  a_r4_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrLeft, wrRight, wrCtrl}));

  // R4: write pulses last one cycle
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    (wrLeft | wrRight | wrCtrl) |=> !(wrLeft | wrRight | wrCtrl));

  // R5: left volume moves only with its pulse
  a_r5_left_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrLeft |-> $stable(volLeft));

  // R5: right volume moves only with its pulse
  a_r5_right_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrRight |-> $stable(volRight));

  // R11: control fields persist between control writes
  a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |-> ($stable(wordLen) && $stable(softReset)));
endmodule

bind serctl_regs serctl_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrLeft    (wrLeft),
  .wrRight   (wrRight),
  .wrCtrl    (wrCtrl),
  .volLeft   (volLeft),
  .volRight  (volRight),
  .wordLen   (wordLen),
  .softReset (softReset)
);

// File: tb/test_serctl_regs.sv
module test_serctl_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, sdataIn = 1'b0, latchIn = 1'b0;
  logic pinX2 = 1'b0, pinX4 = 1'b0, pinMute = 1'b0, pinDeemph = 1'b0;
  logic [1:0] pinMode = 2'b00;
  logic [13:0] volLeft, volRight;
  logic wrLeft, wrRight, wrCtrl, intpX2, intpX4, softReset, muteEff;
  logic [1:0] wordLen, modeEff, deemphSel;

  int compared = 0;
  int mismatched = 0;
  int cntL = 0, cntR = 0, cntC = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serctl_regs i_serctl_regs (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdataIn(sdataIn), .latchIn(latchIn),
    .pinX2(pinX2), .pinX4(pinX4), .pinMode(pinMode), .pinMute(pinMute),
    .pinDeemph(pinDeemph), .volLeft(volLeft), .volRight(volRight),
    .wrLeft(wrLeft), .wrRight(wrRight), .wrCtrl(wrCtrl), .intpX2(intpX2),
    .intpX4(intpX4), .wordLen(wordLen), .softReset(softReset),
    .muteEff(muteEff), .modeEff(modeEff), .deemphSel(deemphSel)
  );

  always @(posedge clk) begin
    if (wrLeft)  cntL++;
    if (wrRight) cntR++;
    if (wrCtrl)  cntC++;
  end

  task automatic check(string req, string what, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(bit b);
    sdataIn = b; waitCyc(3);
    sclkIn = 1'b1; waitCyc(3);
    sclkIn = 1'b0; waitCyc(3);
  endtask

  task automatic sendBits(logic [15:0] w);
    for (int i = 15; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic commit();
    latchIn = 1'b1; waitCyc(5);
    latchIn = 1'b0; waitCyc(3);
  endtask

  task automatic writeWord(logic [15:0] w);
    sendBits(w);
    commit();
  endtask

  task automatic checkCtrlZero(string req);
    check(req, "intpX2", intpX2, 0);
    check(req, "intpX4", intpX4, 0);
    check(req, "wordLen", wordLen, 0);
    check(req, "softReset", softReset, 0);
    check(req, "muteEff", muteEff, 0);
    check(req, "modeEff", modeEff, 0);
    check(req, "deemphSel", deemphSel, 0);
  endtask

  task automatic t_reset_defaults();
    check("R1", "volLeft", volLeft, 14'h3FFF);
    check("R1", "volRight", volRight, 14'h3FFF);
    checkCtrlZero("R1");
  endtask

  task automatic t_volume_writes();
    int l0 = cntL, r0 = cntR, c0 = cntC;
    writeWord({14'h1234, 2'b00});
    check("R5", "volLeft", volLeft, 14'h1234);
    check("R5", "volRight untouched", volRight, 14'h3FFF);
    check("R4", "left pulses", cntL - l0, 1);
    writeWord({14'h0ABC, 2'b10});
    check("R3", "volRight", volRight, 14'h0ABC);
    check("R3", "volLeft untouched", volLeft, 14'h1234);
    check("R4", "right pulses", cntR - r0, 1);
    check("R4", "no ctrl pulse", cntC - c0, 0);
  endtask

  task automatic t_control_fields();
    int c0 = cntC;
    writeWord(16'h0800 | 16'h0100 | 16'h0040 | 16'h0020 | 16'h000C | 16'h0001);
    check("R6", "intpX2", intpX2, 1);
    check("R6", "intpX4", intpX4, 0);
    check("R6", "wordLen", wordLen, 2'b01);
    check("R6", "muteEff", muteEff, 1);
    check("R6", "modeEff", modeEff, 2'b10);
    check("R6", "deemphSel", deemphSel, 2'b11);
    check("R6", "softReset", softReset, 0);
    check("R4", "ctrl pulses", cntC - c0, 1);
    writeWord(16'h0400 | 16'h0200 | 16'h0010 | 16'h0008 | 16'h0001);
    check("R6", "intpX4", intpX4, 1);
    check("R6", "wordLen 16", wordLen, 2'b10);
    check("R6", "mode 01", modeEff, 2'b01);
    check("R6", "deemph 32k", deemphSel, 2'b10);
  endtask

  task automatic t_reserved_bits();
    writeWord(16'hF001);
    checkCtrlZero("R7");
  endtask

  task automatic t_addr_unused();
    int l0 = cntL, r0 = cntR, c0 = cntC;
    writeWord({14'h0555, 2'b11});
    check("R3", "addr11 volLeft", volLeft, 14'h1234);
    check("R3", "addr11 volRight", volRight, 14'h0ABC);
    checkCtrlZero("R3");
    check("R3", "addr11 pulses", (cntL - l0) + (cntR - r0) + (cntC - c0), 0);
  endtask

  task automatic t_pin_merge();
    pinX2 = 1'b1; pinX4 = 1'b1; pinMode = 2'b11; pinMute = 1'b1; pinDeemph = 1'b1;
    waitCyc(2);
    check("R8", "intpX2", intpX2, 1);
    check("R8", "intpX4", intpX4, 1);
    check("R8", "modeEff", modeEff, 2'b11);
    check("R8", "muteEff", muteEff, 1);
    check("R8", "deemph pin", deemphSel, 2'b01);
    writeWord(16'h0008 | 16'h0001);
    check("R8", "deemph forced", deemphSel, 2'b01);
    pinX2 = 1'b0; pinX4 = 1'b0; pinMode = 2'b01; pinMute = 1'b0; pinDeemph = 1'b0;
    waitCyc(2);
    check("R8", "deemph reg", deemphSel, 2'b10);
    check("R8", "mode pin only", modeEff, 2'b01);
    pinMode = 2'b00;
    waitCyc(1);
  endtask

  task automatic t_soft_reset();
    writeWord(16'h0080 | 16'h0040 | 16'h0100 | 16'h0001);
    waitCyc(20);
    check("R11", "softReset held", softReset, 1);
    check("R11", "mute kept", muteEff, 1);
    check("R11", "wordLen kept", wordLen, 2'b01);
    writeWord(16'h0001);
    check("R11", "softReset cleared", softReset, 0);
  endtask

  task automatic t_overlong();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    writeWord({14'h2222, 2'b00});
    check("R2", "last 16 kept", volLeft, 14'h2222);
  endtask

  task automatic t_same_cycle();
    logic [15:0] w = {14'h3456, 2'b00};
    sendBits(w);
    sdataIn = 1'b1; waitCyc(3);
    sclkIn = 1'b1; latchIn = 1'b1; waitCyc(5);
    sclkIn = 1'b0; latchIn = 1'b0; waitCyc(3);
    check("R9", "commit before shift", volLeft, 14'h3456);
    latchIn = 1'b1; waitCyc(5); latchIn = 1'b0; waitCyc(3);
    // shifted word is now {w[14:0],1}: address 01, control bits 11:2 = w[10:1]
    check("R9", "bit shifted after", wordLen, w[8:7]);
    writeWord(16'h0001);
  endtask

  task automatic t_hw_reset();
    writeWord({14'h0101, 2'b10});
    writeWord(16'h0C01);
    rstN = 1'b0; waitCyc(3); rstN = 1'b1; waitCyc(3);
    check("R10", "volLeft", volLeft, 14'h3FFF);
    check("R10", "volRight", volRight, 14'h3FFF);
    checkCtrlZero("R10");
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);
    t_reset_defaults();
    t_volume_writes();
    t_control_fields();
    t_reserved_bits();
    t_addr_unused();
    t_pin_merge();
    t_soft_reset();
    t_overlong();
    t_same_cycle();
    t_hw_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule